// File: doc/BRIEF.md
# Calendar Clock with Daylight Saving

This block is a calendar clock. It holds seconds, minutes, hours, day of week, date, month and a two-digit year. Each single-cycle pulse on the one-hertz `tick` input advances the time by one second, with carries through every field. The carries follow the month lengths, and every year divisible by four is a leap year. When daylight saving is enabled, the block moves the clock forward one hour on the first Sunday in April and repeats one hour on the last Sunday in October. The October repeat happens only once in that night.

Software reaches all fields and a control byte through one address port. Writes take effect on the clock edge, and reads return `rd_data` combinationally from `addr`. The control byte holds four bits:
- a hold bit that freezes counting while the fields are loaded;
- a data-mode bit that selects binary or BCD;
- an hour-format bit that selects 12-hour or 24-hour counting;
- the daylight-saving enable.

The time is kept internally as binary counts. It is encoded in the current mode on every read and on the byte outputs, and each written byte is decoded in the current mode. After every completed one-second update the block raises `upd_pulse` for one clock.

Top module: `cal_clock_dst`

## Requirements
- R1: While control bit 0 (hold) is 1, `tick` changes no time field and raises no `upd_pulse`. While it is 0, each `tick` advances the time by one second.
- R2: Addresses 0 to 6 select seconds, minutes, hours, day of week, date, month and year. Address 7 is control: bit 0 hold, bit 1 data mode, bit 2 hour format, bit 3 daylight enable. Control bits change only by a write. After reset the time is 00:00:00, day of week 1, date 1, month 1, year 0, and control is 0x4.
- R3: A data mode of 1 gives plain binary bytes. A data mode of 0 gives BCD bytes, with tens in bits 7:4 and units in bits 3:0. Writes are decoded in the same encoding.
- R4: An hour format of 1 counts hours 0 to 23. An hour format of 0 shows 12, 1 … 11, with bit 7 of the hours byte as the PM flag. The PM flag changes when 11:59:59 rolls to 12:00:00.
- R5: Seconds carry into minutes, minutes into hours, and hours into the day. Each new day advances the date and advances the day of week from 1 (Sunday) to 7, wrapping back to 1.
- R6: Months have their Gregorian lengths. February has 29 days when the year is a multiple of 4. December 31 rolls to January 1 of the next year, and year 99 rolls to 00.
- R7: With daylight enabled, on a Sunday (day of week 1) in April with a date of 1 to 7, the next second after 1:59:59 AM is 3:00:00 AM.
- R8: With daylight enabled, on a Sunday in October with a date of 25 to 31, the first 1:59:59 AM is followed by 1:00:00 AM. The second 1:59:59 AM that night is followed by 2:00:00. A change of date (by carry or by a write) re-arms the repeat.
- R9: With daylight disabled, 1:59:59 AM is always followed by 2:00:00 AM.
- R10: `upd_pulse` is high for exactly the one clock that follows the edge at which a tick updated the time. It is never raised otherwise.
- R11: A write and a tick in the same cycle: the write is applied and that tick is dropped, with no `upd_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Field address for read and write |
| wr_data | input | 8 | Write byte, in the current encoding |
| rd_data | output | 8 | Byte at `addr`, in the current encoding |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| dow_o | output | 8 | Day-of-week byte |
| date_o | output | 8 | Date byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte |
| upd_pulse | output | 1 | One-clock pulse after each completed update |

## Verification
The hardest case to reach is the autumn repeat. It needs a Sunday in late October, the enable bit set, and then a full extra hour of ticks before the second arrival at 1:59:59. The bench loads that moment under hold, then drives 3600 consecutive ticks against its model, checking both the first and the second passage. The other rare moments (the April skip, February 28/29 in leap and common years, and year 99 to 00) are also loaded directly under hold. Random loads near minute, hour and day edges cover both encodings and both hour formats.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int CAL_AW = 3;
    localparam int BYTE_W = 8;
    localparam int NFIELD = 8;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] date;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic dst_en;
        logic hr24;
        logic bin_mode;
        logic set_hold;
    } cal_ctrl_t;

    typedef enum logic [CAL_AW-1:0] {
        A_SEC  = 3'd0,
        A_MIN  = 3'd1,
        A_HOUR = 3'd2,
        A_DOW  = 3'd3,
        A_DATE = 3'd4,
        A_MON  = 3'd5,
        A_YEAR = 3'd6,
        A_CTRL = 3'd7
    } cal_addr_e;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] t;
        logic [6:0] u;
        t = v / 7'd10;
        u = v % 7'd10;
        return {t[3:0], u[3:0]};
    endfunction

    function automatic logic [6:0] from_bcd(input logic [7:0] b);
        logic [6:0] t;
        t = {3'b0, b[7:4]};
        return 7'(t * 7'd10) + {3'b0, b[3:0]};
    endfunction

    function automatic logic [7:0] byte_enc(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic logic [7:0] hour_enc(input logic [4:0] h, input logic bin,
                                            input logic hr24);
        logic [4:0] h12;
        logic [7:0] body;
        if (hr24) return byte_enc({2'b0, h}, bin);
        h12  = (h >= 5'd12) ? h - 5'd12 : h;
        if (h12 == 5'd0) h12 = 5'd12;
        body = byte_enc({2'b0, h12}, bin);
        return {(h >= 5'd12), body[6:0]};
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
        case (mon)
            4'd2:                      return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_next.sv
module cal_next
    import cal_pkg::*;
(
    input  cal_time_t cur,
    input  logic      fall_done,
    input  logic      dst_en,
    output cal_time_t nxt,
    output logic      nxt_fall_done
);

    logic at_edge;
    logic spring;
    logic fall;

    always_comb begin
        at_edge = (cur.hour == 5'd1) && (cur.min == 6'd59) && (cur.sec == 6'd59);
        spring  = dst_en && at_edge && (cur.dow == 3'd1) && (cur.mon == 4'd4) &&
                  (cur.date <= 5'd7);
        fall    = dst_en && at_edge && (cur.dow == 3'd1) && (cur.mon == 4'd10) &&
                  (cur.date >= 5'd25) && !fall_done;

        nxt           = cur;
        nxt_fall_done = fall_done;

        if (spring) begin
            nxt.hour = 5'd3;
            nxt.min  = 6'd0;
            nxt.sec  = 6'd0;
        end else if (fall) begin
            nxt.hour      = 5'd1;
            nxt.min       = 6'd0;
            nxt.sec       = 6'd0;
            nxt_fall_done = 1'b1;
        end else if (cur.sec != 6'd59) begin
            nxt.sec = cur.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (cur.min != 6'd59) begin
                nxt.min = cur.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (cur.hour != 5'd23) begin
                    nxt.hour = cur.hour + 5'd1;
                end else begin
                    nxt.hour      = 5'd0;
                    nxt_fall_done = 1'b0;
                    nxt.dow       = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
                    if (cur.date < month_days(cur.mon, cur.year)) begin
                        nxt.date = cur.date + 5'd1;
                    end else begin
                        nxt.date = 5'd1;
                        if (cur.mon < 4'd12) begin
                            nxt.mon = cur.mon + 4'd1;
                        end else begin
                            nxt.mon  = 4'd1;
                            nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cal_view.sv
module cal_view
    import cal_pkg::*;
(
    input  cal_time_t                       cur,
    input  cal_ctrl_t                       ctrl,
    output logic [NFIELD-1:0][BYTE_W-1:0]   view
);

    always_comb begin
        view[A_SEC]  = byte_enc({1'b0, cur.sec}, ctrl.bin_mode);
        view[A_MIN]  = byte_enc({1'b0, cur.min}, ctrl.bin_mode);
        view[A_HOUR] = hour_enc(cur.hour, ctrl.bin_mode, ctrl.hr24);
        view[A_DOW]  = byte_enc({4'b0, cur.dow}, ctrl.bin_mode);
        view[A_DATE] = byte_enc({2'b0, cur.date}, ctrl.bin_mode);
        view[A_MON]  = byte_enc({3'b0, cur.mon}, ctrl.bin_mode);
        view[A_YEAR] = byte_enc(cur.year, ctrl.bin_mode);
        view[A_CTRL] = {4'b0, ctrl};
    end

endmodule

// File: rtl/cal_clock_dst.sv
module cal_clock_dst
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [CAL_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] sec_o,
    output logic [BYTE_W-1:0] min_o,
    output logic [BYTE_W-1:0] hour_o,
    output logic [BYTE_W-1:0] dow_o,
    output logic [BYTE_W-1:0] date_o,
    output logic [BYTE_W-1:0] mon_o,
    output logic [BYTE_W-1:0] year_o,
    output logic              upd_pulse
);

    cal_time_t cur;
    cal_time_t nxt;
    cal_ctrl_t ctrl;
    logic      fall_done;
    logic      nxt_fall_done;
    logic      past_ok;
    logic      step;

    logic [NFIELD-1:0][BYTE_W-1:0] view;
    logic [6:0] wval;
    logic [7:0] hbody;
    logic [6:0] hval;
    logic [4:0] hdec;

    cal_next u_next (
        .cur           (cur),
        .fall_done     (fall_done),
        .dst_en        (ctrl.dst_en),
        .nxt           (nxt),
        .nxt_fall_done (nxt_fall_done)
    );

    cal_view u_view (
        .cur  (cur),
        .ctrl (ctrl),
        .view (view)
    );

    assign step = tick && !ctrl.set_hold && !wr_en;

    always_comb begin
        wval  = ctrl.bin_mode ? wr_data[6:0] : from_bcd(wr_data);
        hbody = ctrl.hr24 ? wr_data : {1'b0, wr_data[6:0]};
        hval  = ctrl.bin_mode ? hbody[6:0] : from_bcd(hbody);
        if (ctrl.hr24) begin
            hdec = hval[4:0];
        end else begin
            hdec = ((hval == 7'd12) ? 5'd0 : hval[4:0]) + (wr_data[7] ? 5'd12 : 5'd0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '{year: 7'd0, mon: 4'd1, date: 5'd1, dow: 3'd1,
                           hour: 5'd0, min: 6'd0, sec: 6'd0};
            ctrl      <= '{dst_en: 1'b0, hr24: 1'b1, bin_mode: 1'b0, set_hold: 1'b0};
            fall_done <= 1'b0;
            upd_pulse <= 1'b0;
            past_ok   <= 1'b0;
        end else begin
            past_ok   <= 1'b1;
            upd_pulse <= 1'b0;
            if (wr_en) begin
                case (cal_addr_e'(addr))
                    A_SEC:  cur.sec  <= wval[5:0];
                    A_MIN:  cur.min  <= wval[5:0];
                    A_HOUR: cur.hour <= hdec;
                    A_DOW:  cur.dow  <= wval[2:0];
                    A_DATE: begin
                        cur.date  <= wval[4:0];
                        fall_done <= 1'b0;
                    end
                    A_MON:  cur.mon  <= wval[3:0];
                    A_YEAR: cur.year <= wval;
                    default: ctrl    <= wr_data[3:0];
                endcase
            end else if (step) begin
                cur       <= nxt;
                fall_done <= nxt_fall_done;
                upd_pulse <= 1'b1;
            end
        end
    end

    assign rd_data = view[addr];
    assign sec_o   = view[A_SEC];
    assign min_o   = view[A_MIN];
    assign hour_o  = view[A_HOUR];
    assign dow_o   = view[A_DOW];
    assign date_o  = view[A_DATE];
    assign mon_o   = view[A_MON];
    assign year_o  = view[A_YEAR];

    // R1
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(ctrl.set_hold && !wr_en) |-> $stable(cur));

    // R10
    pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && upd_pulse |-> $past(tick && !ctrl.set_hold && !wr_en));

    // R5
    sec_advance_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(step && cur.sec < 6'd59) |-> cur.sec == $past(cur.sec) + 6'd1);

    // R8
    fall_mark_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $rose(fall_done) |-> cur.hour == 5'd1 && cur.min == 6'd0 && cur.sec == 6'd0);

    // R7
    spring_jump_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(step && ctrl.dst_en && cur.mon == 4'd4 && cur.dow == 3'd1 &&
                         cur.date <= 5'd7 && cur.hour == 5'd1) && cur.hour != 5'd1
        |-> cur.hour == 5'd3);

    // R2
    ctrl_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(wr_en && addr == A_CTRL) |-> $stable(ctrl));

endmodule

// File: tb/tb_cal_clock_dst.sv
module tb_cal_clock_dst;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data, sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o;
    logic       upd_pulse;

    int nchk = 0;
    int nfail = 0;

    int ms, mm, mh, mdw, mdt, mmo, myr;
    bit mfd;
    bit mbin, mh24, mdst;

    always #10ns clk = ~clk;

    cal_clock_dst dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .mon_o(mon_o),
        .year_o(year_o), .upd_pulse(upd_pulse)
    );

    function automatic logic [7:0] enc(int v, bit bin);
        if (bin) return 8'(v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] henc(int h, bit bin, bit h24);
        int h12;
        if (h24) return enc(h, bin);
        h12 = h % 12;
        if (h12 == 0) h12 = 12;
        return enc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction

    function automatic int dim(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] ctrl_byte(bit hold);
        return {4'b0, mdst, mh24, mbin, hold};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_time(input string req);
        logic [55:0] act, exp;
        act = {year_o, mon_o, date_o, dow_o, hour_o, min_o, sec_o};
        exp = {enc(myr, mbin), enc(mmo, mbin), enc(mdt, mbin), enc(mdw, mbin),
               henc(mh, mbin, mh24), enc(mm, mbin), enc(ms, mbin)};
        chk(act == exp, req, 64'(act), 64'(exp));
    endtask

    task automatic model_tick();
        bit edge159;
        edge159 = (mh == 1 && mm == 59 && ms == 59);
        if (mdst && edge159 && mdw == 1 && mmo == 4 && mdt <= 7) begin
            mh = 3; mm = 0; ms = 0;
        end else if (mdst && edge159 && mdw == 1 && mmo == 10 && mdt >= 25 && !mfd) begin
            mh = 1; mm = 0; ms = 0; mfd = 1;
        end else begin
            ms++;
            if (ms == 60) begin
                ms = 0; mm++;
                if (mm == 60) begin
                    mm = 0; mh++;
                    if (mh == 24) begin
                        mh = 0; mfd = 0;
                        mdw = (mdw == 7) ? 1 : mdw + 1;
                        mdt++;
                        if (mdt > dim(mmo, myr)) begin
                            mdt = 1; mmo++;
                            if (mmo == 13) begin
                                mmo = 1;
                                myr = (myr == 99) ? 0 : myr + 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        addr = 3'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int h, input int m, input int s, input int dw,
                        input int dt, input int mo, input int yr);
        do_write(7, ctrl_byte(1'b1));
        do_write(0, enc(s, mbin));
        do_write(1, enc(m, mbin));
        do_write(2, henc(h, mbin, mh24));
        do_write(3, enc(dw, mbin));
        do_write(4, enc(dt, mbin));
        do_write(5, enc(mo, mbin));
        do_write(6, enc(yr, mbin));
        do_write(7, ctrl_byte(1'b0));
        ms = s; mm = m; mh = h; mdw = dw; mdt = dt; mmo = mo; myr = yr; mfd = 0;
    endtask

    task automatic tick_check(input string req);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
        check_time(req);
        chk(upd_pulse == 1'b1, "R10 pulse after update", 64'(upd_pulse), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        mbin = 0; mh24 = 1; mdst = 0;
        ms = 0; mm = 0; mh = 0; mdw = 1; mdt = 1; mmo = 1; myr = 0; mfd = 0;
        check_time("R2 reset time");
        addr = 3'd7; #1;
        chk(rd_data == 8'h04, "R2 reset control", 64'(rd_data), 64'h04);
        chk(upd_pulse == 1'b0, "R10 no pulse at reset", 64'(upd_pulse), 64'd0);

        // R1 hold freezes time, no pulse
        load(13, 45, 30, 3, 15, 6, 21);
        do_write(7, ctrl_byte(1'b1));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            chk(upd_pulse == 1'b0, "R1 no pulse while held", 64'(upd_pulse), 64'd0);
        end
        check_time("R1 time frozen while held");
        addr = 3'd7; #1;
        chk(rd_data == ctrl_byte(1'b1), "R2 control readback", 64'(rd_data),
            64'(ctrl_byte(1'b1)));
        do_write(7, ctrl_byte(1'b0));
        tick_check("R1 advances after release");
        @(negedge clk);
        chk(upd_pulse == 1'b0, "R10 pulse one clock", 64'(upd_pulse), 64'd0);

        // R3 binary read port value
        mbin = 1;
        load(9, 8, 7, 2, 3, 4, 55);
        addr = 3'd6; #1;
        chk(rd_data == 8'd55, "R3 binary year readback", 64'(rd_data), 64'd55);
        mbin = 0;
        load(9, 8, 7, 2, 3, 4, 55);
        addr = 3'd6; #1;
        chk(rd_data == 8'h55, "R3 BCD year readback", 64'(rd_data), 64'h55);

        // R4 12-hour noon and 1 PM
        mh24 = 0;
        load(11, 59, 59, 4, 10, 5, 30);
        tick_check("R4 11:59:59 AM to 12 PM");
        chk(hour_o == 8'h92, "R4 noon byte", 64'(hour_o), 64'h92);
        load(12, 59, 59, 4, 10, 5, 30);
        tick_check("R4 12 PM to 1 PM");
        chk(hour_o == 8'h81, "R4 1 PM byte", 64'(hour_o), 64'h81);
        load(23, 59, 59, 7, 10, 5, 30);
        tick_check("R5 midnight in 12-hour, dow wraps");
        chk(hour_o == 8'h12, "R4 midnight byte", 64'(hour_o), 64'h12);
        mh24 = 1;

        // R6 calendar edges
        load(23, 59, 59, 1, 28, 2, 4);
        tick_check("R6 Feb 28 leap year");
        load(23, 59, 59, 1, 28, 2, 3);
        tick_check("R6 Feb 28 common year");
        load(23, 59, 59, 1, 30, 4, 10);
        tick_check("R6 April 30");
        load(23, 59, 59, 5, 31, 12, 99);
        tick_check("R6 year 99 rollover");

        // R7 spring skip and R9 disabled
        mdst = 1;
        load(1, 59, 59, 1, 3, 4, 24);
        tick_check("R7 spring forward");
        chk(hour_o == 8'h03, "R7 hour 3", 64'(hour_o), 64'h03);
        load(1, 59, 59, 1, 10, 4, 24);
        tick_check("R7 second Sunday no skip");
        mdst = 0;
        load(1, 59, 59, 1, 5, 4, 24);
        tick_check("R9 disabled spring");
        chk(hour_o == 8'h02, "R9 hour 2", 64'(hour_o), 64'h02);
        load(1, 59, 59, 1, 27, 10, 24);
        tick_check("R9 disabled autumn");

        // R8 autumn repeat once
        mdst = 1;
        load(1, 59, 59, 1, 27, 10, 24);
        tick_check("R8 first pass repeats");
        chk(hour_o == 8'h01 && min_o == 8'h00, "R8 back to 1:00",
            64'({hour_o, min_o}), 64'h0100);
        for (int i = 0; i < 3600; i++) tick_check("R8 repeated hour");
        chk(hour_o == 8'h02 && min_o == 8'h00, "R8 second pass to 2:00",
            64'({hour_o, min_o}), 64'h0200);

        // R11 write beats tick
        load(10, 30, 10, 2, 2, 2, 2);
        @(negedge clk);
        addr = 3'd0; wr_data = enc(40, mbin); wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; ms = 40;
        check_time("R11 write wins over tick");
        chk(upd_pulse == 1'b0, "R11 no pulse", 64'(upd_pulse), 64'd0);

        // Random loads near edges, mixed modes
        for (int it = 0; it < 40; it++) begin
            int h, m, s, mo, yr, dt, dw, sel;
            mbin = 1'($urandom % 2);
            mh24 = 1'($urandom % 2);
            mdst = 1'($urandom % 2);
            mo = 1 + int'($urandom % 12);
            yr = int'($urandom % 100);
            dt = ((it % 2) == 0) ? dim(mo, yr) : 1 + int'($urandom % dim(mo, yr));
            dw = 1 + int'($urandom % 7);
            sel = int'($urandom % 6);
            h = (sel == 0) ? 23 : (sel == 1) ? 11 : (sel == 2) ? 1 :
                (sel == 3) ? 12 : int'($urandom % 24);
            m = ((it % 3) != 0) ? 59 : int'($urandom % 60);
            s = 57 + int'($urandom % 3);
            load(h, m, s, dw, dt, mo, yr);
            for (int k = 0; k < 3; k++) tick_check("R3 R4 R5 R6 random sequence");
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule